// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's execute stage. When the core raises a take strobe, the block decides what to do with the events pending in that cycle. It can enter a pending exception, enter a hardware interrupt, ask for a system reset, or do nothing. On entry it computes every piece of processor state that changes.

The core supplies the following inputs:
- the exception code and its valid flag
- the interrupt request, together with the vector that the interrupt controller reports for the current mask level
- the current status word, the vector base, the program counter and the stack register (general register 15)
- a flag saying that the current instruction sits in a delay slot

The block returns registered values for:
- the new status word and the saved status
- the saved PC and the saved stack register
- the exception-event and interrupt-event codes
- the next PC
- a kind code, a reset request and a delay-slot clear pulse

Status-word bit positions that other logic decodes:
- block bit at 28
- privileged mode at 30
- register bank at 29
- FPU-disable at 15
- interrupt mask at bits 7:4

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid_i` and `irq_req_i` are both set at a strobe, the exception is handled and the interrupt is not; `intevt_o` keeps its value.
- R2: If status bit 28 (block bit) is set and an exception with a code other than 0x1E0 is pending, the block pulses `reset_req_o`, reports kind 3, and leaves every state output unchanged. Code 0x1E0 under the block bit is entered normally.
- R3: An interrupt is not taken in any of these cases, and the block then reports kind 0 with the state unchanged:
  - the block bit is set
  - `asleep_i` is set
  - `dslot_i` is set
  - `irq_vec_valid_i` is low
- R4: On entry, `ssr_o` gets the old status word, `sgr_o` gets `sp_i`, and status bits 28, 29 and 30 are set in `sr_o`. All other status bits are copied, except as R7 changes them.
- R5: An exception taken with `dslot_i` set stores `pc_i - 2` in `spc_o` and pulses `dslot_clr_o`. Without a delay slot, `spc_o` gets `pc_i`.
- R6: An exception writes its code to `expevt_o`. An interrupt writes its vector to `intevt_o`, sets `pc_o` to vector base + 0x600, and leaves `expevt_o` unchanged.
- R7: Reset-class codes 0x000 and 0x020 clear status bit 15, set status bits 7:4 to 0xF, and set `pc_o` to 0xA0000000.
- R8: TLB-miss codes 0x040 and 0x060 set `pc_o` to vector base + 0x400. Every other non-reset exception code sets `pc_o` to vector base + 0x100.
- R9: The trap code 0x160 adds 2 to the saved PC.
- R10: Outputs change only at the clock edge that samples `take_i` high. `done_o` is high for exactly the cycle after each strobe.
- R11: After reset the outputs are:
  - `sr_o` = 0x700000F0
  - `pc_o` = 0xA0000000
  - all other data outputs and pulses 0
  - kind 0
- R12: `evt_kind_o` encodes the handled event: 0 none, 1 exception, 2 interrupt, 3 reset request. It is valid while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Strobe: evaluate pending events this cycle |
| exc_valid_i | input | 1 | An exception code is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Hardware interrupt request |
| irq_vec_valid_i | input | 1 | Controller has a vector for the current mask |
| irq_vec_i | input | 12 | Interrupt vector from the controller |
| asleep_i | input | 1 | Core is in sleep state |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector base |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current general register 15 |
| sr_o | output | 32 | New status word |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved stack register |
| expevt_o | output | 12 | Exception-event code |
| intevt_o | output | 12 | Interrupt-event code |
| pc_o | output | 32 | Next PC |
| evt_kind_o | output | 2 | Handled event kind (R12 encoding) |
| reset_req_o | output | 1 | One-cycle system reset request |
| dslot_clr_o | output | 1 | One-cycle delay-slot flag clear |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on three assumptions about the inputs:
- `take_i` is low throughout reset.
- `vbr_i` is only meaningful at the strobe edge.
- Nothing other than a strobe is expected to move the state outputs.

The bench meets these conditions as follows:
- It holds the strobe low during reset.
- It changes all inputs on falling edges and raises `take_i` for exactly one cycle.
- It leaves an idle cycle after each strobe, so that each `done_o` pulse can be matched to one queued expectation.

Trap and reset codes are sent only outside delay slots, as a real decoder would send them.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int SR_FD_BIT    = 15;
    localparam int SR_BL_BIT    = 28;
    localparam int SR_RB_BIT    = 29;
    localparam int SR_MD_BIT    = 30;
    localparam int SR_IMASK_LSB = 4;
    localparam int IMASK_W      = 4;

    typedef enum logic [1:0] {
        EVT_NONE  = 2'd0,
        EVT_EXC   = 2'd1,
        EVT_IRQ   = 2'd2,
        EVT_RESET = 2'd3
    } evt_kind_e;

    typedef enum logic [1:0] {
        CLS_GENERAL = 2'd0,
        CLS_RESET   = 2'd1,
        CLS_TLBMISS = 2'd2,
        CLS_TRAP    = 2'd3
    } exc_class_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int              CODE_W      = 12,
    parameter logic [CODE_W-1:0] EXEMPT_CODE = 12'h1E0
) (
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              irq_vec_valid_i,
    input  logic              asleep_i,
    input  logic              dslot_i,
    input  logic              bl_i,
    output evt_kind_e         kind_o
);
    logic irq_ok;

    // an interrupt needs an open block bit, an awake core, no delay slot and a vector
    assign irq_ok = irq_req_i && irq_vec_valid_i && !bl_i && !asleep_i && !dslot_i;

    always_comb begin
        kind_o = EVT_NONE;
        if (exc_valid_i) begin
            if (bl_i && (exc_code_i != EXEMPT_CODE)) begin
                kind_o = EVT_RESET;
            end else begin
                kind_o = EVT_EXC;
            end
        end else if (irq_ok) begin
            kind_o = EVT_IRQ;
        end
    end
endmodule

// File: rtl/exc_classifier.sv
module exc_classifier
    import exc_entry_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int NUM_RST = 2,
    parameter int NUM_TLB = 2,
    parameter logic [NUM_RST*CODE_W-1:0] RST_CODES = {12'h020, 12'h000},
    parameter logic [NUM_TLB*CODE_W-1:0] TLB_CODES = {12'h060, 12'h040},
    parameter logic [CODE_W-1:0]         TRAP_CODE = 12'h160
) (
    input  logic [CODE_W-1:0] code_i,
    output exc_class_e        cls_o
);
    logic [NUM_RST-1:0] rst_hit;
    logic [NUM_TLB-1:0] tlb_hit;

    for (genvar i = 0; i < NUM_RST; i++) begin : g_rst
        assign rst_hit[i] = (code_i == RST_CODES[i*CODE_W +: CODE_W]);
    end

    for (genvar j = 0; j < NUM_TLB; j++) begin : g_tlb
        assign tlb_hit[j] = (code_i == TLB_CODES[j*CODE_W +: CODE_W]);
    end

    always_comb begin
        if (|rst_hit) begin
            cls_o = CLS_RESET;
        end else if (|tlb_hit) begin
            cls_o = CLS_TLBMISS;
        end else if (code_i == TRAP_CODE) begin
            cls_o = CLS_TRAP;
        end else begin
            cls_o = CLS_GENERAL;
        end
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  RESET_PC  = 32'hA000_0000,
    parameter int               GEN_OFF   = 'h100,
    parameter int               TLB_OFF   = 'h400,
    parameter int               IRQ_OFF   = 'h600,
    parameter int               INSN_STEP = 2
) (
    input  evt_kind_e       kind_i,
    input  exc_class_e      cls_i,
    input  logic [XLEN-1:0] vbr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            dslot_i,
    output logic [XLEN-1:0] new_pc_o,
    output logic [XLEN-1:0] new_spc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_STEP);

    logic [XLEN-1:0] back_pc;

    // a delay-slot fault rewinds to the branch
    assign back_pc = dslot_i ? (pc_i - STEP) : pc_i;

    always_comb begin
        new_spc_o = back_pc;
        if (kind_i == EVT_EXC && cls_i == CLS_TRAP) begin
            new_spc_o = back_pc + STEP;
        end
    end

    always_comb begin
        new_pc_o = vbr_i + XLEN'(GEN_OFF);
        if (kind_i == EVT_IRQ) begin
            new_pc_o = vbr_i + XLEN'(IRQ_OFF);
        end else begin
            unique case (cls_i)
                CLS_RESET:   new_pc_o = RESET_PC;
                CLS_TLBMISS: new_pc_o = vbr_i + XLEN'(TLB_OFF);
                default:     new_pc_o = vbr_i + XLEN'(GEN_OFF);
            endcase
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CODE_W   = 12,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0] RESET_SR = 32'h7000_00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              irq_vec_valid_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    input  logic              asleep_i,
    input  logic              dslot_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   sp_i,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [1:0]        evt_kind_o,
    output logic              reset_req_o,
    output logic              dslot_clr_o,
    output logic              done_o
);
    localparam logic [XLEN-1:0] ENTRY_SET =
        (XLEN'(1) << SR_BL_BIT) | (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_RB_BIT);
    localparam logic [XLEN-1:0] FD_MASK    = XLEN'(1) << SR_FD_BIT;
    localparam logic [XLEN-1:0] IMASK_FULL = XLEN'((1 << IMASK_W) - 1) << SR_IMASK_LSB;

    typedef struct packed {
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic [XLEN-1:0]   pc;
        evt_kind_e         kind;
        logic              reset_req;
        logic              dslot_clr;
        logic              done;
    } state_t;

    state_t          st_d, st_q;
    evt_kind_e       kind_w;
    exc_class_e      cls_w;
    logic [XLEN-1:0] new_pc_w;
    logic [XLEN-1:0] new_spc_w;

    exc_arbiter #(.CODE_W(CODE_W)) u_arb (
        .exc_valid_i     (exc_valid_i),
        .exc_code_i      (exc_code_i),
        .irq_req_i       (irq_req_i),
        .irq_vec_valid_i (irq_vec_valid_i),
        .asleep_i        (asleep_i),
        .dslot_i         (dslot_i),
        .bl_i            (sr_i[SR_BL_BIT]),
        .kind_o          (kind_w)
    );

    exc_classifier #(.CODE_W(CODE_W)) u_cls (
        .code_i (exc_code_i),
        .cls_o  (cls_w)
    );

    exc_target #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_tgt (
        .kind_i    (kind_w),
        .cls_i     (cls_w),
        .vbr_i     (vbr_i),
        .pc_i      (pc_i),
        .dslot_i   (dslot_i),
        .new_pc_o  (new_pc_w),
        .new_spc_o (new_spc_w)
    );

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.reset_req = 1'b0;
        st_d.dslot_clr = 1'b0;
        if (take_i) begin
            st_d.done = 1'b1;
            st_d.kind = kind_w;
            if (kind_w == EVT_RESET) begin
                st_d.reset_req = 1'b1;
            end else if (kind_w == EVT_EXC || kind_w == EVT_IRQ) begin
                st_d.ssr = sr_i;
                st_d.sgr = sp_i;
                st_d.spc = new_spc_w;
                st_d.pc  = new_pc_w;
                st_d.sr  = sr_i | ENTRY_SET;
                if (kind_w == EVT_EXC) begin
                    st_d.expevt    = exc_code_i;
                    st_d.dslot_clr = dslot_i;
                    if (cls_w == CLS_RESET) begin
                        st_d.sr = (st_d.sr & ~FD_MASK) | IMASK_FULL;
                    end
                end else begin
                    st_d.intevt = irq_vec_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr        <= RESET_SR;
            st_q.ssr       <= '0;
            st_q.spc       <= '0;
            st_q.sgr       <= '0;
            st_q.expevt    <= '0;
            st_q.intevt    <= '0;
            st_q.pc        <= RESET_PC;
            st_q.kind      <= EVT_NONE;
            st_q.reset_req <= 1'b0;
            st_q.dslot_clr <= 1'b0;
            st_q.done      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o        = st_q.sr;
    assign ssr_o       = st_q.ssr;
    assign spc_o       = st_q.spc;
    assign sgr_o       = st_q.sgr;
    assign expevt_o    = st_q.expevt;
    assign intevt_o    = st_q.intevt;
    assign pc_o        = st_q.pc;
    assign evt_kind_o  = st_q.kind;
    assign reset_req_o = st_q.reset_req;
    assign dslot_clr_o = st_q.dslot_clr;
    assign done_o      = st_q.done;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN    = 32,
    parameter int IRQ_OFF = 'h600
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_i,
    input logic            exc_valid_i,
    input logic [XLEN-1:0] sr_i,
    input logic [XLEN-1:0] vbr_i,
    input logic [XLEN-1:0] sr_o,
    input logic [XLEN-1:0] pc_o,
    input logic [1:0]      evt_kind_o,
    input logic            reset_req_o,
    input logic            done_o
);
    p_done_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> done_o);

    p_no_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> !done_o);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ($stable(pc_o) && $stable(sr_o)));

    p_entry_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (evt_kind_o == 2'd1 || evt_kind_o == 2'd2))
            |-> (sr_o[28] && sr_o[29] && sr_o[30]));

    p_reset_req_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> (done_o && evt_kind_o == 2'd3));

    p_exc_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && exc_valid_i) |=> (evt_kind_o == 2'd1 || evt_kind_o == 2'd3));

    p_irq_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !exc_valid_i && sr_i[28]) |=> (evt_kind_o == 2'd0));

    p_irq_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !exc_valid_i) |=>
            (evt_kind_o != 2'd2 || pc_o == $past(vbr_i) + XLEN'(IRQ_OFF)));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_i),
    .exc_valid_i (exc_valid_i),
    .sr_i        (sr_i),
    .vbr_i       (vbr_i),
    .sr_o        (sr_o),
    .pc_o        (pc_o),
    .evt_kind_o  (evt_kind_o),
    .reset_req_o (reset_req_o),
    .done_o      (done_o)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [11:0] exc_code_i = '0;
    logic        irq_req_i = 1'b0;
    logic        irq_vec_valid_i = 1'b0;
    logic [11:0] irq_vec_i = '0;
    logic        asleep_i = 1'b0;
    logic        dslot_i = 1'b0;
    logic [31:0] sr_i = '0, vbr_i = '0, pc_i = '0, sp_i = '0;
    logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;
    logic [1:0]  evt_kind_o;
    logic        reset_req_o, dslot_clr_o, done_o;

    int checks = 0;
    int failures = 0;
    int n_evt = 0;

    typedef struct {
        logic [1:0]  kind;
        logic [31:0] sr, ssr, spc, sgr, pc;
        logic [11:0] expevt, intevt;
        logic        rst, dclr;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t model;

    always #2.5 clk = ~clk;

    exc_entry_seq u_dut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic fire(input bit ev, input logic [11:0] code, input bit irq,
                        input bit vv, input logic [11:0] vec, input bit slp,
                        input bit ds, input logic [31:0] sr, input string tag);
        exp_t e;
        bit   bl;
        @(negedge clk);
        n_evt++;
        exc_valid_i = ev; exc_code_i = code; irq_req_i = irq;
        irq_vec_valid_i = vv; irq_vec_i = vec; asleep_i = slp; dslot_i = ds;
        sr_i = sr; vbr_i = 32'h8C00_0000 + 32'(n_evt) * 32'h1000;
        pc_i = 32'h0C00_1000 + 32'(n_evt) * 16; sp_i = 32'h0CFF_F000 - 32'(n_evt) * 4;
        e = model; e.rst = 1'b0; e.dclr = 1'b0; e.tag = tag;
        bl = sr[28];
        if (ev) e.kind = (bl && code != 12'h1E0) ? 2'd3 : 2'd1;
        else if (irq && vv && !bl && !slp && !ds) e.kind = 2'd2;
        else e.kind = 2'd0;
        if (e.kind == 2'd3) e.rst = 1'b1;
        if (e.kind == 2'd1 || e.kind == 2'd2) begin
            e.ssr = sr; e.sgr = sp_i; e.sr = sr | 32'h7000_0000;
            e.spc = pc_i - (ds ? 32'd2 : 32'd0);
            if (e.kind == 2'd1) begin
                e.dclr = ds; e.expevt = code;
                if (code == 12'h160) e.spc = e.spc + 32'd2;
                if (code == 12'h000 || code == 12'h020) begin
                    e.sr = (e.sr & ~32'h0000_8000) | 32'h0000_00F0;
                    e.pc = 32'hA000_0000;
                end else if (code == 12'h040 || code == 12'h060) e.pc = vbr_i + 32'h400;
                else e.pc = vbr_i + 32'h100;
            end else begin
                e.intevt = vec; e.pc = vbr_i + 32'h600;
            end
        end
        q.push_back(e);
        model = e;
        take_i = 1'b1;
        @(negedge clk);
        take_i = 1'b0; exc_valid_i = 1'b0; irq_req_i = 1'b0;
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "done without strobe", 32'(done_o), 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(evt_kind_o == e.kind, {e.tag, " R12"}, "kind", 32'(evt_kind_o), 32'(e.kind));
                chk(sr_o == e.sr, e.tag, "sr", sr_o, e.sr);
                chk(ssr_o == e.ssr, e.tag, "ssr", ssr_o, e.ssr);
                chk(spc_o == e.spc, e.tag, "spc", spc_o, e.spc);
                chk(sgr_o == e.sgr, e.tag, "sgr", sgr_o, e.sgr);
                chk(expevt_o == e.expevt, e.tag, "expevt", 32'(expevt_o), 32'(e.expevt));
                chk(intevt_o == e.intevt, e.tag, "intevt", 32'(intevt_o), 32'(e.intevt));
                chk(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
                chk(reset_req_o == e.rst, e.tag, "reset_req", 32'(reset_req_o), 32'(e.rst));
                chk(dslot_clr_o == e.dclr, e.tag, "dslot_clr", 32'(dslot_clr_o), 32'(e.dclr));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(sr_o == 32'h7000_00F0, "R11", "sr", sr_o, 32'h7000_00F0);
        chk(pc_o == 32'hA000_0000, "R11", "pc", pc_o, 32'hA000_0000);
        chk(ssr_o == 0 && spc_o == 0 && sgr_o == 0, "R11", "saved", ssr_o | spc_o | sgr_o, 32'd0);
        chk(expevt_o == 0 && intevt_o == 0, "R11", "events", 32'(expevt_o | intevt_o), 32'd0);
        chk(!done_o && !reset_req_o && !dslot_clr_o && evt_kind_o == 0, "R11", "pulses",
            32'({done_o, reset_req_o, dslot_clr_o, evt_kind_o}), 32'd0);
        model.kind = 2'd0; model.sr = 32'h7000_00F0; model.ssr = '0; model.spc = '0;
        model.sgr = '0; model.pc = 32'hA000_0000; model.expevt = '0; model.intevt = '0;

        fire(1, 12'h180, 0, 0, 12'h0,   0, 0, 32'h0000_0003, "R4 R6 R8 general");
        fire(1, 12'h040, 0, 0, 12'h0,   0, 0, 32'h0000_8070, "R8 tlb miss read");
        fire(1, 12'h060, 0, 0, 12'h0,   0, 0, 32'h4000_0000, "R8 tlb miss write");
        fire(1, 12'h160, 0, 0, 12'h0,   0, 0, 32'h0000_0001, "R9 trap");
        fire(1, 12'h0E0, 0, 0, 12'h0,   0, 1, 32'h0000_0040, "R5 delay slot");
        fire(0, 12'h0,   1, 1, 12'h320, 0, 0, 32'h0000_0030, "R6 interrupt");
        fire(1, 12'h100, 1, 1, 12'h3C0, 0, 0, 32'h0000_0000, "R1 exc over irq");
        fire(1, 12'h180, 0, 0, 12'h0,   0, 0, 32'h1000_0000, "R2 masked exc");
        fire(1, 12'h1E0, 0, 0, 12'h0,   0, 0, 32'h1000_0000, "R2 exempt code");
        fire(0, 12'h0,   1, 1, 12'h340, 0, 0, 32'h1000_0000, "R3 irq under bl");
        fire(0, 12'h0,   1, 1, 12'h360, 1, 0, 32'h0000_0000, "R3 irq asleep");
        fire(0, 12'h0,   1, 1, 12'h380, 0, 1, 32'h0000_0000, "R3 irq delay slot");
        fire(0, 12'h0,   1, 0, 12'h3A0, 0, 0, 32'h0000_0000, "R3 irq no vector");
        fire(1, 12'h000, 0, 0, 12'h0,   0, 0, 32'h0000_8003, "R7 power reset");
        fire(1, 12'h020, 0, 0, 12'h0,   0, 0, 32'h0000_8000, "R7 manual reset");
        fire(0, 12'h0,   1, 1, 12'h5A0, 0, 0, 32'h0000_8000, "R6 second interrupt");

        // R10 idle: inputs move with no strobe, outputs hold
        sr_i = 32'hFFFF_FFFF; pc_i = 32'h1234_5678; exc_valid_i = 1'b1;
        repeat (5) @(negedge clk);
        exc_valid_i = 1'b0;
        chk(pc_o == model.pc, "R10", "idle pc", pc_o, model.pc);
        chk(sr_o == model.sr, "R10", "idle sr", sr_o, model.sr);
        chk(!done_o, "R10", "idle done", 32'(done_o), 32'd0);
        chk(q.size() == 0, "R10", "pending results", 32'(q.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule